// File: doc/BRIEF.md
# Floating-Point CORDIC Input Aligner

This block sits in front of an integer circular-rotation CORDIC core so that the core can take floating-point operands. Each of the two vector components, x and y, arrives as a sign, a biased exponent and an unsigned mantissa. The aligner picks the larger of the two exponents as the shared exponent. It shifts the mantissa that belongs to the smaller exponent right by the difference between the two exponents. It then writes both magnitudes into signed two's-complement integer words. The core can then add and subtract the two words on every iteration with no renormalization.

Each output word is wider than the mantissa by a sign bit and two guard bits. One guard bit absorbs the growth of the vector length, up to a factor of √2, during circular rotation. The other covers the fact that the gain correction is applied only after the last iteration. The scheme is valid only for circular rotations, where the vector length is preserved apart from the constant gain. The default mantissa width is 28 bits, which suits a 30-iteration core.

Operands enter through a valid/ready handshake and appear one clock later in an output register. That register holds its contents while the consumer stalls.

Top module: `fp_cordic_aligner`

## Requirements
- R1: `out_exp` equals the larger of `x_exp` and `y_exp` of the accepted operand pair, with both exponents read as unsigned numbers.
- R2: The mantissa of the component whose exponent is larger passes to its output word with its magnitude unchanged. When the two exponents are equal, neither mantissa is shifted.
- R3: The mantissa of the component whose exponent is smaller is shifted right by the exponent difference, and the bits shifted out are dropped. The resulting magnitude is floor(mantissa / 2^difference).
- R4: When the exponent difference is equal to or larger than MANT_W, the smaller-exponent component's output word is zero.
- R5: A sign input of 1 makes the output word the two's-complement negative of the aligned magnitude, and a sign input of 0 gives the positive value. A negative sign on a zero magnitude gives an all-zero word.
- R6: Each output word is MANT_W+3 bits wide, and its three top bits (the sign bit and the two guard bits) are always equal.
- R7: A pair that is accepted on a clock edge (`in_valid` and `in_ready` both high) sets `out_valid` high after exactly that one edge. `out_valid` falls after an edge on which the output is taken and no new pair is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_exp`, `out_x` and `out_y` hold their values. An input offered during such a stall is not accepted.
- R9: While `rst_n` is low, `out_valid` is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Aligner can accept a pair |
| x_sign | input | 1 | Sign of x (1 = negative) |
| x_exp | input | EXP_W | Biased exponent of x |
| x_mant | input | MANT_W | Unsigned mantissa of x |
| y_sign | input | 1 | Sign of y (1 = negative) |
| y_exp | input | EXP_W | Biased exponent of y |
| y_mant | input | MANT_W | Unsigned mantissa of y |
| out_valid | output | 1 | Aligned pair is present |
| out_ready | input | 1 | Consumer takes the aligned pair |
| out_exp | output | EXP_W | Shared exponent |
| out_x | output | MANT_W+3 | Aligned x, two's complement with guard bits |
| out_y | output | MANT_W+3 | Aligned y, two's complement with guard bits |

## Verification
The assertions check a set of properties on every cycle:
- the guard-bit agreement of both words;
- the one-cycle latency;
- the stall behaviour;
- the shared exponent being the maximum;
- the zero forced on a far-shifted component;
- the idle state under reset.

Other behaviour appears only in the bench's sweeps: exact shifted magnitudes across every exponent difference from -34 to +34 for several mantissa patterns and all sign combinations, negative zero, exponent extremes, and the refusal of an input offered during a stall.

// File: rtl/fca_pkg.sv
// Package: shared constants and types for the floating-point CORDIC aligner.
// Assumes: each output word carries one sign bit plus GUARD_BITS headroom bits.
package fca_pkg;
    localparam int GUARD_BITS = 2;

    // Which component owns the larger exponent
    typedef enum logic {
        BIG_IS_X = 1'b0,
        BIG_IS_Y = 1'b1
    } big_side_e;
endpackage

// File: rtl/fca_exp_cmp.sv
// Module: exponent comparator.
// It finds the larger of two unsigned exponents, the absolute difference between them
// and the side that owns the larger one. On a tie, x counts as the larger side and the
// difference is zero. Purely combinational.
module fca_exp_cmp
    import fca_pkg::*;
#(
    parameter int EXP_W = 8
) (
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    output logic [EXP_W-1:0] exp_max,
    output logic [EXP_W-1:0] exp_diff,
    output big_side_e        big_side
);
    // Compare the exponents and form the difference and the selection
    always_comb begin
        if (exp_a >= exp_b) begin
            big_side = BIG_IS_X;
            exp_max  = exp_a;
            exp_diff = exp_a - exp_b;
        end else begin
            big_side = BIG_IS_Y;
            exp_max  = exp_b;
            exp_diff = exp_b - exp_a;
        end
    end
endmodule

// File: rtl/fca_rshift.sv
// Module: logarithmic right shifter for an unsigned magnitude.
// There is one mux stage for each shift-amount bit below log2(DATA_W). A shift amount
// equal to or larger than DATA_W gives zero. Assumes SHIFT_W >= $clog2(DATA_W) and that
// SHIFT_W+1 bits can represent DATA_W.
module fca_rshift #(
    parameter int DATA_W  = 28,
    parameter int SHIFT_W = 8
) (
    input  logic [DATA_W-1:0]  data_in,
    input  logic [SHIFT_W-1:0] shift_amt,
    output logic [DATA_W-1:0]  data_out
);
    localparam int STAGES = $clog2(DATA_W);

    logic [DATA_W-1:0] stage_q [0:STAGES];
    logic              too_far;

    assign stage_q[0] = data_in;

    // One stage per power-of-two shift distance
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        assign stage_q[k+1] = shift_amt[k] ? (stage_q[k] >> (2**k)) : stage_q[k];
    end

    // Detect a shift that moves every bit out of the word
    assign too_far  = ({1'b0, shift_amt} >= (SHIFT_W+1)'(DATA_W));
    assign data_out = too_far ? '0 : stage_q[STAGES];
endmodule

// File: rtl/fca_sign_word.sv
// Module: converts an unsigned magnitude plus a sign into a wider two's-complement
// word. The extra top bits act as headroom. Assumes WORD_W > MAG_W. Purely combinational.
module fca_sign_word #(
    parameter int MAG_W  = 28,
    parameter int WORD_W = 31
) (
    input  logic              neg,
    input  logic [MAG_W-1:0]  mag,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] mag_ext;

    // Zero-extend the magnitude, then negate it when the sign is set
    always_comb begin
        mag_ext = WORD_W'(mag);
        word    = neg ? (~mag_ext + WORD_W'(1)) : mag_ext;
    end
endmodule

// File: rtl/fp_cordic_aligner.sv
// Module: floating-point CORDIC input aligner (top).
// It accepts x and y as sign, exponent and mantissa. Both components are moved to the
// larger exponent by right-shifting the smaller one. Both are output as two's-complement
// words with one sign bit and two guard bits. There is one register stage behind a
// valid/ready handshake.
// Assumes: circular rotations only. The mantissas are unsigned magnitudes.
module fp_cordic_aligner
    import fca_pkg::*;
#(
    parameter int MANT_W = 28,
    parameter int EXP_W  = 8,
    localparam int WORD_W = MANT_W + 1 + GUARD_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              x_sign,
    input  logic [EXP_W-1:0]  x_exp,
    input  logic [MANT_W-1:0] x_mant,
    input  logic              y_sign,
    input  logic [EXP_W-1:0]  y_exp,
    input  logic [MANT_W-1:0] y_mant,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [EXP_W-1:0]  out_exp,
    output logic [WORD_W-1:0] out_x,
    output logic [WORD_W-1:0] out_y
);
    logic [EXP_W-1:0]  exp_max;
    logic [EXP_W-1:0]  exp_diff;
    big_side_e         big_side;
    logic [MANT_W-1:0] small_mant;
    logic [MANT_W-1:0] small_shifted;
    logic [MANT_W-1:0] x_aligned;
    logic [MANT_W-1:0] y_aligned;
    logic [WORD_W-1:0] x_word;
    logic [WORD_W-1:0] y_word;

    fca_exp_cmp #(.EXP_W(EXP_W)) exp_cmp_i (
        .exp_a    (x_exp),
        .exp_b    (y_exp),
        .exp_max  (exp_max),
        .exp_diff (exp_diff),
        .big_side (big_side)
    );

    // Route the smaller-exponent mantissa into the single shared shifter
    assign small_mant = (big_side == BIG_IS_Y) ? x_mant : y_mant;

    fca_rshift #(.DATA_W(MANT_W), .SHIFT_W(EXP_W)) rshift_i (
        .data_in   (small_mant),
        .shift_amt (exp_diff),
        .data_out  (small_shifted)
    );

    // Put the shifted and the unshifted mantissa back on their own components
    always_comb begin
        if (big_side == BIG_IS_Y) begin
            x_aligned = small_shifted;
            y_aligned = y_mant;
        end else begin
            x_aligned = x_mant;
            y_aligned = small_shifted;
        end
    end

    fca_sign_word #(.MAG_W(MANT_W), .WORD_W(WORD_W)) sign_x_i (
        .neg  (x_sign),
        .mag  (x_aligned),
        .word (x_word)
    );

    fca_sign_word #(.MAG_W(MANT_W), .WORD_W(WORD_W)) sign_y_i (
        .neg  (y_sign),
        .mag  (y_aligned),
        .word (y_word)
    );

    // Accept a new pair when the output register is empty or is being drained
    assign in_ready = !out_valid || out_ready;

    // Output register: load on acceptance, hold during a stall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_exp   <= '0;
            out_x     <= '0;
            out_y     <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_exp <= exp_max;
                out_x   <= x_word;
                out_y   <= y_word;
            end
        end
    end
endmodule

// File: rtl/fca_checker.sv
// Module: property checker for fp_cordic_aligner. It is attached to the top module
// through the bind statement below.
module fca_checker #(
    parameter int MANT_W = 28,
    parameter int EXP_W  = 8,
    localparam int WORD_W = MANT_W + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [EXP_W-1:0]  x_exp,
    input logic [EXP_W-1:0]  y_exp,
    input logic              out_valid,
    input logic              out_ready,
    input logic [EXP_W-1:0]  out_exp,
    input logic [WORD_W-1:0] out_x,
    input logic [WORD_W-1:0] out_y
);
    logic fire;
    assign fire = in_valid && in_ready;

    AST_EXP_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_exp == $past((x_exp >= y_exp) ? x_exp : y_exp)); // R1

    AST_FAR_Y_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (int'(x_exp) - int'(y_exp) >= MANT_W)) |=> out_y == '0); // R4

    AST_FAR_X_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (int'(y_exp) - int'(x_exp) >= MANT_W)) |=> out_x == '0); // R4

    AST_GUARD_X: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x[WORD_W-1:WORD_W-3] == 3'b000 || out_x[WORD_W-1:WORD_W-3] == 3'b111)); // R6

    AST_GUARD_Y: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_y[WORD_W-1:WORD_W-3] == 3'b000 || out_y[WORD_W-1:WORD_W-3] == 3'b111)); // R6

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_exp) && $stable(out_x) && $stable(out_y))); // R8

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R9
endmodule

bind fp_cordic_aligner fca_checker #(.MANT_W(MANT_W), .EXP_W(EXP_W)) chk_i (.*);

// File: tb/fp_cordic_aligner_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps the exponent difference, the mantissa patterns and the sign combinations.
// The expected words are computed with integer arithmetic. It also covers exponent
// extremes, negative zero, stalls and reset.
module fp_cordic_aligner_tb_top;
    localparam int MANT_W = 28;
    localparam int EXP_W  = 8;
    localparam int WORD_W = MANT_W + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              x_sign = 1'b0;
    logic [EXP_W-1:0]  x_exp = '0;
    logic [MANT_W-1:0] x_mant = '0;
    logic              y_sign = 1'b0;
    logic [EXP_W-1:0]  y_exp = '0;
    logic [MANT_W-1:0] y_mant = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [EXP_W-1:0]  out_exp;
    logic [WORD_W-1:0] out_x;
    logic [WORD_W-1:0] out_y;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fp_cordic_aligner #(.MANT_W(MANT_W), .EXP_W(EXP_W)) dut_i (.*);

    // Report and stop a run that hangs
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    // Expected signed word for a component
    function automatic longint expect_word(input logic sgn, input longint mant, input int sh);
        longint mag;
        if (sh >= MANT_W) mag = 0;
        else mag = mant / (longint'(1) << sh);
        return sgn ? -mag : mag;
    endfunction

    function automatic bit guard_ok(input logic [WORD_W-1:0] w);
        return (w[WORD_W-1:WORD_W-3] == 3'b000) || (w[WORD_W-1:WORD_W-3] == 3'b111);
    endfunction

    // Drive one pair, let it be accepted, then check the registered result
    task automatic run_pair(input logic sx, input int ex, input longint mx,
                            input logic sy, input int ey, input longint my);
        int     shx;
        int     shy;
        longint ew;
        @(negedge clk);
        x_sign = sx; x_exp = EXP_W'(ex); x_mant = MANT_W'(mx);
        y_sign = sy; y_exp = EXP_W'(ey); y_mant = MANT_W'(my);
        in_valid = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        shx = (ey > ex) ? ey - ex : 0;
        shy = (ex > ey) ? ex - ey : 0;
        chk("R7 out_valid after one edge", longint'(out_valid), 1);
        chk("R1 shared exponent", longint'(out_exp), longint'((ex > ey) ? ex : ey));
        ew = expect_word(sx, mx, shx);
        chk((shx == 0) ? "R2 R5 x word unshifted" : ((shx >= MANT_W) ? "R4 R5 x word far" : "R3 R5 x word shifted"),
            longint'($signed(out_x)), ew);
        ew = expect_word(sy, my, shy);
        chk((shy == 0) ? "R2 R5 y word unshifted" : ((shy >= MANT_W) ? "R4 R5 y word far" : "R3 R5 y word shifted"),
            longint'($signed(out_y)), ew);
        chk("R6 guard bits x", longint'(guard_ok(out_x)), 1);
        chk("R6 guard bits y", longint'(guard_ok(out_y)), 1);
    endtask

    initial begin
        longint pats [4];
        pats[0] = 64'h0FFFFFFF;
        pats[1] = 64'h08000000;
        pats[2] = 64'h00000001;
        pats[3] = 64'h05A5A5A5;

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6: sweep of exponent difference, patterns and signs
        for (int d = -34; d <= 34; d++) begin
            for (int p = 0; p < 4; p++) begin
                for (int s = 0; s < 4; s++) begin
                    run_pair(s[0], 100 + d, pats[p], s[1], 100, pats[(p + 1) % 4]);
                end
            end
        end

        // R4: exponent extremes
        run_pair(1'b0, 255, 64'h0ABCDEF, 1'b1, 0, 64'h0FFFFFFF);
        run_pair(1'b1, 0, 64'h0FFFFFFF, 1'b0, 255, 64'h0123456);
        // R2: both exponents zero
        run_pair(1'b1, 0, 64'h0FFFFFFF, 1'b1, 0, 64'h0FFFFFFF);
        // R5: negative zero gives zero
        run_pair(1'b1, 40, 64'h0, 1'b1, 40, 64'h0);
        chk("R5 negative zero x all-zero", longint'(out_x), 0);

        // R7: out_valid falls once taken and no new pair
        @(negedge clk);
        chk("R7 out_valid drops when idle", longint'(out_valid), 0);

        // R8: stall holds data and refuses new input
        @(negedge clk);
        x_sign = 1'b0; x_exp = 8'd50; x_mant = 28'h1234567;
        y_sign = 1'b1; y_exp = 8'd48; y_mant = 28'h0FFFFFF;
        in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R8 in_ready low in stall", longint'(in_ready), 0);
        x_exp = 8'd90; x_mant = 28'h0000F00; y_exp = 8'd91; y_mant = 28'h0000ABC; y_sign = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 exponent held", longint'(out_exp), 50);
        chk("R8 x held", longint'($signed(out_x)), longint'(28'h1234567));
        chk("R8 y held", longint'($signed(out_y)), -longint'(28'h0FFFFFF / 4));
        chk("R8 out_valid held", longint'(out_valid), 1);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 new pair after release exp", longint'(out_exp), 91);
        chk("R8 new pair after release x", longint'($signed(out_x)), longint'(28'h0000F00 / 2));
        chk("R8 new pair after release y", longint'($signed(out_y)), longint'(28'h0000ABC));

        // R9: reset in the middle of traffic clears out_valid
        @(negedge clk);
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 out_valid cleared by reset", longint'(out_valid), 0);
        rst_n = 1'b1; out_ready = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule